// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Repeat Masks

This block holds four alarm bytes: seconds, minutes, hours and day of month. Each byte carries a BCD value and a repeat mask in its top bit. On every once-per-second strobe the block compares the alarm bytes with the BCD time supplied by a separate clock block. When the fields that the mask combination selects all agree, it fires. A firing emits a single-cycle interrupt pulse and sets a sticky alarm flag. The flag clears when the flags register is read.

Software loads the alarm through a byte write port, which selects one of the four bytes. A write whose BCD content is out of range for its field is dropped, so the stored alarm is always a legal time. The four mask bits together choose how often the alarm repeats: monthly, daily, hourly, every minute or every second. A read port returns any alarm byte exactly as it was stored.

Top module: `rtcAlarm`

## Requirements
- R1: After reset the alarm bytes read back as seconds 0x00, minutes 0x00, hours 0x00 and date 0x01, and both the interrupt and the flag are low.
- R2: A write to seconds (wrSel 0) or minutes (wrSel 1) stores the whole byte only when bits 6:4 form a tens digit of 0 to 5 and bits 3:0 form a units digit of 0 to 9; any other write leaves the byte unchanged. rdSel uses the same encoding as wrSel.
- R3: A write to hours (wrSel 2) stores the whole byte only when bits 5:0 hold a BCD value from 00 to 23; any other write is ignored.
- R4: A write to date (wrSel 3) stores the whole byte only when bits 5:0 hold valid BCD digits that are not zero; any other write is ignored.
- R5: With no mask bit set, the alarm fires on a strobe at which date, hours, minutes and seconds all match.
- R6: With only the date mask set, the alarm fires when hours, minutes and seconds match, giving a daily repeat.
- R7: With the date and hour masks set and the others clear, the alarm fires when minutes and seconds match, giving an hourly repeat.
- R8: With the date, hour and minute masks set and the seconds mask clear, the alarm fires when seconds match, giving a repeat every minute.
- R9: Any other mask combination fires the alarm on every strobe.
- R10: Matching is evaluated only on cycles where secTick is high. Seconds and minutes are compared on bits 6:0, and hours and date on bits 5:0. A firing drives alarmIrq high for exactly the one cycle after that clock edge.
- R11: A firing sets alarmFlag. The flag stays set until a cycle with flagRd high clears it, and a firing in the same cycle as flagRd wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle strobe, once per second |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD |
| curDate | input | 8 | Current day of month, BCD |
| wrEn | input | 1 | Alarm byte write enable |
| wrSel | input | 2 | Alarm byte select for writes |
| wrData | input | 8 | Alarm byte write data |
| rdSel | input | 2 | Alarm byte select for readback |
| rdData | output | 8 | Selected alarm byte |
| flagRd | input | 1 | Flags register read, clears the alarm flag |
| alarmIrq | output | 1 | One-cycle alarm interrupt pulse |
| alarmFlag | output | 1 | Sticky alarm flag |

## Verification
The interrupt properties assume that secTick is never high on two consecutive cycles. Without that assumption, back-to-back firings could hold the interrupt for longer than one cycle. The bench therefore always leaves at least one idle cycle between strobes, and it never drives a strobe in the same cycle as a write. The properties also assume that the supplied time is stable whenever the strobe is high. The bench holds the time inputs constant from one negative edge to the next around each strobe, and it builds most strobe times from the current alarm bytes so that every repeat mode sees both hits and near misses.

// File: rtl/rtcAlarmPkg.sv
package rtcAlarmPkg;
  localparam int DATA_W    = 8;
  localparam int FIELD_CNT = 4;
  localparam int SEL_W     = $clog2(FIELD_CNT);
  localparam int MASK_BIT  = DATA_W - 1;

  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_DATE = 3;

  typedef enum logic [2:0] {
    PER_MONTH,
    PER_DAY,
    PER_HOUR,
    PER_MINUTE,
    PER_SECOND
  } periodE;

  typedef struct packed {
    logic [FIELD_CNT-1:0] wrStb;
  } ctrlStrobeS;
endpackage

// File: rtl/rtcAlarmRegs.sv
module rtcAlarmRegs
  import rtcAlarmPkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobeS                        strobes,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic [FIELD_CNT-1:0][DATA_W-1:0]  curTime,
  output logic [FIELD_CNT-1:0][DATA_W-1:0]  regFile,
  output logic [FIELD_CNT-1:0]              fieldMatch,
  output logic [FIELD_CNT-1:0]              maskBits
);
  logic [3:0] units;
  assign units = wrData[3:0];

  for (genvar i = 0; i < FIELD_CNT; i++) begin : gField
    localparam logic [2:0] TENS_MAX = (i == FLD_HOUR) ? 3'd2 :
                                      (i == FLD_DATE) ? 3'd3 : 3'd5;
    localparam logic [DATA_W-1:0] CMP_MASK = (i <= FLD_MIN) ? 8'h7F : 8'h3F;
    localparam logic [DATA_W-1:0] RST_VAL  = (i == FLD_DATE) ? 8'h01 : 8'h00;

    logic [2:0]        tens;
    logic              valid;
    logic [DATA_W-1:0] q;

    assign tens = wrData[6:4] & CMP_MASK[6:4];

    always_comb begin
      valid = (units <= 4'd9) && (tens <= TENS_MAX);
      if ((i == FLD_HOUR) && (tens == 3'd2) && (units > 4'd3)) valid = 1'b0;
      if ((i == FLD_DATE) && (tens == 3'd0) && (units == 4'd0)) valid = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) q <= RST_VAL;
      else if (strobes.wrStb[i] && valid) q <= wrData;
    end

    assign regFile[i]    = q;
    assign fieldMatch[i] = ((curTime[i] ^ q) & CMP_MASK) == '0;
    assign maskBits[i]   = q[MASK_BIT];
  end
endmodule

// File: rtl/rtcAlarmCtrl.sv
module rtcAlarmCtrl
  import rtcAlarmPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [SEL_W-1:0]     wrSel,
  input  logic                 secTick,
  input  logic                 flagRd,
  input  logic [FIELD_CNT-1:0] fieldMatch,
  input  logic [FIELD_CNT-1:0] maskBits,
  output ctrlStrobeS           strobes,
  output logic                 alarmIrq,
  output logic                 alarmFlag
);
  periodE               period;
  logic [FIELD_CNT-1:0] needMatch;
  logic                 fire;

  always_comb begin
    strobes = '0;
    if (wrEn) strobes.wrStb[wrSel] = 1'b1;
  end

  always_comb begin
    unique case (maskBits)
      4'b0000: period = PER_MONTH;
      4'b1000: period = PER_DAY;
      4'b1100: period = PER_HOUR;
      4'b1110: period = PER_MINUTE;
      default: period = PER_SECOND;
    endcase
  end

  always_comb begin
    unique case (period)
      PER_MONTH:  needMatch = 4'b1111;
      PER_DAY:    needMatch = 4'b0111;
      PER_HOUR:   needMatch = 4'b0011;
      PER_MINUTE: needMatch = 4'b0001;
      default:    needMatch = 4'b0000;
    endcase
  end

  assign fire = secTick && (&(fieldMatch | ~needMatch));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmIrq  <= 1'b0;
      alarmFlag <= 1'b0;
    end else begin
      alarmIrq  <= fire;
      alarmFlag <= fire | (alarmFlag & ~flagRd);
    end
  end
endmodule

// File: rtl/rtcAlarm.sv
module rtcAlarm
  import rtcAlarmPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [DATA_W-1:0] curSec,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curDate,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  input  logic              flagRd,
  output logic              alarmIrq,
  output logic              alarmFlag
);
  ctrlStrobeS                       strobes;
  logic [FIELD_CNT-1:0][DATA_W-1:0] curTime;
  logic [FIELD_CNT-1:0][DATA_W-1:0] regFile;
  logic [FIELD_CNT-1:0]             fieldMatch;
  logic [FIELD_CNT-1:0]             maskBits;

  assign curTime[FLD_SEC]  = curSec;
  assign curTime[FLD_MIN]  = curMin;
  assign curTime[FLD_HOUR] = curHour;
  assign curTime[FLD_DATE] = curDate;
  assign rdData = regFile[rdSel];

  rtcAlarmCtrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .secTick(secTick),
    .flagRd(flagRd), .fieldMatch(fieldMatch), .maskBits(maskBits),
    .strobes(strobes), .alarmIrq(alarmIrq), .alarmFlag(alarmFlag)
  );

  rtcAlarmRegs uRegs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .curTime(curTime), .regFile(regFile), .fieldMatch(fieldMatch),
    .maskBits(maskBits)
  );
endmodule

// File: rtl/rtcAlarmChk.sv
module rtcAlarmChk (
  input logic        clk,
  input logic        rstN,
  input logic        secTick,
  input logic        flagRd,
  input logic        wrEn,
  input logic        alarmIrq,
  input logic        alarmFlag,
  input logic [31:0] regFile
);
  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |=> !alarmIrq); // R10
  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> $past(secTick)); // R10
  AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> alarmFlag); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !flagRd) |=> alarmFlag); // R11
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> alarmIrq); // R11
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(regFile)); // R2
  AST_DATE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    regFile[29:24] != 6'd0); // R4
endmodule

bind rtcAlarm rtcAlarmChk uChk (
  .clk(clk), .rstN(rstN), .secTick(secTick), .flagRd(flagRd), .wrEn(wrEn),
  .alarmIrq(alarmIrq), .alarmFlag(alarmFlag), .regFile(regFile)
);

// File: tb/tb_rtcAlarm.sv
module tb_rtcAlarm;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic [7:0] curSec = '0, curMin = '0, curHour = '0, curDate = '0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdSel = '0;
  logic [7:0] rdData;
  logic       flagRd = 1'b0;
  logic       alarmIrq, alarmFlag;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  logic [7:0] mReg [4];
  bit  mFlag = 1'b0;

  always #2 clk = ~clk;

  rtcAlarm dut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .curSec(curSec),
    .curMin(curMin), .curHour(curHour), .curDate(curDate), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .flagRd(flagRd), .alarmIrq(alarmIrq), .alarmFlag(alarmFlag)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit writeOk(int sel, logic [7:0] d);
    int t, u, v;
    t = (sel < 2) ? int'(d[6:4]) : int'(d[5:4]);
    u = int'(d[3:0]);
    if (u > 9) return 1'b0;
    v = t * 10 + u;
    case (sel)
      0, 1:    return v <= 59;
      2:       return v <= 23;
      default: return v != 0;
    endcase
  endfunction

  function automatic string modeReq();
    logic [3:0] m;
    m = {mReg[3][7], mReg[2][7], mReg[1][7], mReg[0][7]};
    if (m == 4'b0000) return "R5";
    if (m == 4'b1000) return "R6";
    if (m == 4'b1100) return "R7";
    if (m == 4'b1110) return "R8";
    return "R9";
  endfunction

  function automatic bit expHit(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] d);
    bit ms, mm, mh, md;
    string r;
    ms = (s[6:0] == mReg[0][6:0]);
    mm = (mi[6:0] == mReg[1][6:0]);
    mh = (h[5:0] == mReg[2][5:0]);
    md = (d[5:0] == mReg[3][5:0]);
    r = modeReq();
    if (r == "R5") return ms && mm && mh && md;
    if (r == "R6") return ms && mm && mh;
    if (r == "R7") return ms && mm;
    if (r == "R8") return ms;
    return 1'b1;
  endfunction

  function automatic logic [7:0] toBcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic doWrite(int sel, logic [7:0] d);
    string r;
    r = (sel < 2) ? "R2" : (sel == 2) ? "R3" : "R4";
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'(sel); wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
    if (writeOk(sel, d)) mReg[sel] = d;
    @(negedge clk);
    rdSel = 2'(sel);
    #0.5;
    check(rdData == mReg[sel], r, "readback after write", rdData, mReg[sel]);
  endtask

  task automatic doTick(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] d);
    bit e;
    string r;
    r = modeReq();
    e = expHit(s, mi, h, d);
    @(negedge clk);
    curSec = s; curMin = mi; curHour = h; curDate = d; secTick = 1'b1;
    @(posedge clk); #1;
    secTick = 1'b0;
    mFlag = mFlag | e;
    @(negedge clk);
    check(alarmIrq == e, r, "irq after tick", alarmIrq, e);
    check(alarmFlag == mFlag, "R11", "flag after tick", alarmFlag, mFlag);
    @(negedge clk);
    check(alarmIrq == 1'b0, "R10", "irq one cycle", alarmIrq, 0);
  endtask

  task automatic doFlagRead(bit withFire);
    @(negedge clk);
    flagRd = 1'b1;
    if (withFire) begin
      curSec = mReg[0]; curMin = mReg[1]; curHour = mReg[2]; curDate = mReg[3];
      secTick = 1'b1;
    end
    @(posedge clk); #1;
    flagRd = 1'b0; secTick = 1'b0;
    mFlag = withFire;
    @(negedge clk);
    check(alarmFlag == mFlag, "R11", "flag after read", alarmFlag, mFlag);
  endtask

  task automatic randTime(output logic [7:0] s, output logic [7:0] mi,
                          output logic [7:0] h, output logic [7:0] d);
    s = toBcd(int'($urandom_range(59)));
    mi = toBcd(int'($urandom_range(59)));
    h = toBcd(int'($urandom_range(23)));
    d = toBcd(int'($urandom_range(31, 1)));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, mi, h, d;
    void'($urandom(32'h5EED_0042));
    mReg[0] = 8'h00; mReg[1] = 8'h00; mReg[2] = 8'h00; mReg[3] = 8'h01;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      rdSel = 2'(i); #0.5;
      check(rdData == mReg[i], "R1", "reset byte", rdData, mReg[i]);
    end
    check(alarmIrq == 1'b0, "R1", "reset irq", alarmIrq, 0);
    check(alarmFlag == 1'b0, "R1", "reset flag", alarmFlag, 0);

    // directed range checks
    doWrite(0, 8'h60); doWrite(0, 8'h5A); doWrite(0, 8'h59);
    doWrite(1, 8'h7F); doWrite(1, 8'hB0);
    doWrite(2, 8'h24); doWrite(2, 8'h1A); doWrite(2, 8'h23);
    doWrite(3, 8'h00); doWrite(3, 8'h80); doWrite(3, 8'h31);

    // monthly: miss on date, then hit (R5)
    doWrite(0, 8'h30); doWrite(1, 8'h30); doWrite(2, 8'h12); doWrite(3, 8'h15);
    doTick(8'h30, 8'h30, 8'h12, 8'h16);
    doTick(8'h30, 8'h30, 8'h12, 8'h15);
    doFlagRead(1'b0);
    // compare ignores bit 7 of seconds input (R10)
    doTick(8'hB0, 8'h30, 8'h12, 8'h15);
    // daily (R6)
    doWrite(3, 8'h95);
    doTick(8'h30, 8'h30, 8'h12, 8'h02);
    doTick(8'h30, 8'h30, 8'h13, 8'h02);
    // hourly (R7)
    doWrite(2, 8'h92);
    doTick(8'h30, 8'h30, 8'h05, 8'h09);
    doTick(8'h31, 8'h30, 8'h05, 8'h09);
    // minute (R8)
    doWrite(1, 8'hB0);
    doTick(8'h30, 8'h11, 8'h05, 8'h09);
    doTick(8'h29, 8'h11, 8'h05, 8'h09);
    // every second (R9)
    doWrite(0, 8'hB0);
    doTick(8'h01, 8'h02, 8'h03, 8'h04);
    // set beats clear in same cycle (R11)
    doFlagRead(1'b1);
    doFlagRead(1'b0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int act;
      act = int'($urandom_range(9));
      if (act < 3) begin
        int sel;
        logic [7:0] v;
        sel = int'($urandom_range(3));
        if ($urandom_range(1) == 0) v = 8'($urandom);
        else begin
          case (sel)
            0, 1: v = toBcd(int'($urandom_range(59)));
            2:    v = toBcd(int'($urandom_range(23)));
            default: v = toBcd(int'($urandom_range(39, 1)));
          endcase
          v[7] = ($urandom_range(3) != 0);
        end
        doWrite(sel, v);
      end else if (act < 9) begin
        randTime(s, mi, h, d);
        if ($urandom_range(1) == 0) begin
          s = {1'b0, mReg[0][6:0]}; mi = {1'b0, mReg[1][6:0]};
          h = {2'b00, mReg[2][5:0]}; d = {2'b00, mReg[3][5:0]};
          case ($urandom_range(4))
            0: s = toBcd(int'($urandom_range(59)));
            1: mi = toBcd(int'($urandom_range(59)));
            2: h = toBcd(int'($urandom_range(23)));
            3: d = toBcd(int'($urandom_range(31, 1)));
            default: ;
          endcase
        end
        doTick(s, mi, h, d);
      end else begin
        doFlagRead(1'b0);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule